// File: doc/BRIEF.md
# Descriptor DMA Channel Register Block

This block holds the per-channel control and status state of a descriptor-driven DMA engine that has 32 channels. It sits on a 32-bit register bus that accepts only full-word accesses. Each channel owns a 128-byte window. The block keeps, for each channel, a 16-bit status word, a command pointer and three 32-bit condition-select words (interrupt, branch and wait). The descriptor sequencer reads its control signals from the block's outputs.

Software never writes the status word through the control port directly. It writes a control word whose upper half is a bit mask and whose lower half holds new bit values. The block merges that word into the status word and then derives the ACTIVE and DEAD flags. Three kinds of output go to the sequencer:
- a level run request per channel;
- a one-cycle flush strobe per channel;
- a one-cycle pointer-loaded strobe per channel, with the aligned pointer value.

The register decode sorts each word address into one of seven kinds: control, status, pointer-low, interrupt-select, branch-select, wait-select and read-as-zero. A write to the control kind goes through the merge path. Every other write kind is a plain store, and the pointer-low store can be locked. The block has no multi-cycle sequence. All state changes take effect at the clock edge that samples the access.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every status word, command pointer and select word of every channel is zero. All run requests, flush strobes and load strobes are low, and `bus_rdata` is zero.
- R2: The byte address selects the channel with bits 11:7 and the register word with bits 6:2. A write takes effect only when `bus_be` is 4'hF. A write with any other strobe pattern changes no register and raises no strobe.
- R3: A write to word 0 (control) uses bits 31:16 as a mask and bits 15:0 as values. Only value bits 15 (RUN), 14 (PAUSE), 13 (FLUSH), 12 (WAKE) and 7:0 (device status) are accepted. Any other value bit is taken as 0. Each masked status bit takes the value bit; each unmasked bit keeps its old value.
- R4: After the merge, WAKE (bit 12) set forces ACTIVE (bit 10) to 1. RUN set also forces ACTIVE to 1 and clears DEAD (bit 11).
- R5: PAUSE set after the merge clears ACTIVE, and this overrides R4.
- R6: When a control write takes RUN from 1 to 0, ACTIVE and DEAD are cleared. If FLUSH is then set, FLUSH is cleared as well.
- R7: A control write whose merged FLUSH bit is 1 pulses `flush_req[ch]` for exactly the one cycle after the write edge. This holds both in the R6 case and when FLUSH stays set.
- R8: A write to word 3 (command pointer low) is ignored while that channel's RUN or ACTIVE bit is set. Otherwise the pointer stores the value with bits 3:0 cleared. In the next cycle, `ptr_load[ch]` pulses for one cycle and `ptr_addr` holds the stored pointer.
- R9: A write to word 1 stores bits 15:0 into the status word directly, and status reads return the word with bits 31:16 as 0. Words 4, 5 and 6 (interrupt, branch and wait select) store and read back all 32 bits.
- R10: A read of word 0 returns 0. A read of any word other than 1, 3, 4, 5 and 6 also returns 0. `bus_rdata` updates at the clock edge that samples `bus_rd` and shows the value from before any write in the same cycle.
- R11: `run_req[ch]` equals the ACTIVE bit of channel ch's status word at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write request |
| bus_rd | input | 1 | Register read request |
| bus_addr | input | 10 | Word address (byte address bits 11:2) |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane strobes; only 4'hF writes |
| bus_rdata | output | 32 | Registered read data |
| run_req | output | 32 | Per-channel ACTIVE level to the sequencer |
| flush_req | output | 32 | Per-channel one-cycle flush strobe |
| ptr_load | output | 32 | Per-channel one-cycle pointer-loaded strobe |
| ptr_addr | output | 32 | Aligned command pointer of the last accepted load |

## Verification
Some behaviours are checked by assertions on every cycle:
- right after any control write, that channel never shows PAUSE and ACTIVE together;
- a running, unpaused channel is ACTIVE and not DEAD;
- a pointer strobe follows only an unlocked pointer write;
- a flush strobe follows only a control write;
- at most one channel strobes in any cycle.

The bench scenarios show the rest: the exact bits that the masked merge produces, including unmasked bits that keep their values and non-accepted bits that are masked to zero. They also show the alignment of stored pointers, the registers that read as zero, ignored partial-strobe writes and the addressing of the last channel.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;
    localparam int unsigned ST_RUN    = 15;
    localparam int unsigned ST_PAUSE  = 14;
    localparam int unsigned ST_FLUSH  = 13;
    localparam int unsigned ST_WAKE   = 12;
    localparam int unsigned ST_DEAD   = 11;
    localparam int unsigned ST_ACTIVE = 10;
    localparam logic [15:0] CTRL_ACCEPT = 16'hF0FF;

    typedef enum logic [2:0] {
        K_CTRL, K_STAT, K_PTRLO, K_ISEL, K_BSEL, K_WSEL, K_ZERO
    } reg_kind_e;
endpackage

// File: rtl/dmacr_decode.sv
module dmacr_decode
    import dmacr_pkg::*;
#(
    parameter int NUM_CH    = 32,
    parameter int WIN_SHIFT = 7,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int ADDR_W   = CH_W + WIN_SHIFT
) (
    input  logic [ADDR_W-1:2]   word_addr,
    output logic [CH_W-1:0]     chan,
    output reg_kind_e           kind
);
    localparam int REG_W = WIN_SHIFT - 2;
    logic [REG_W-1:0] reg_idx;

    assign chan    = word_addr[ADDR_W-1:WIN_SHIFT];
    assign reg_idx = word_addr[WIN_SHIFT-1:2];

    always_comb begin
        unique case (reg_idx)
            REG_W'(0): kind = K_CTRL;
            REG_W'(1): kind = K_STAT;
            REG_W'(3): kind = K_PTRLO;
            REG_W'(4): kind = K_ISEL;
            REG_W'(5): kind = K_BSEL;
            REG_W'(6): kind = K_WSEL;
            default:   kind = K_ZERO;
        endcase
    end
endmodule

// File: rtl/dmacr_ctrl_merge.sv
module dmacr_ctrl_merge
    import dmacr_pkg::*;
(
    input  logic [15:0] old_st,
    input  logic [31:0] ctrl_word,
    output logic [15:0] new_st,
    output logic        flush_fire
);
    logic [15:0] mask, val, merged;

    assign mask   = ctrl_word[31:16];
    assign val    = ctrl_word[15:0] & CTRL_ACCEPT;
    assign merged = (val & mask) | (old_st & ~mask);

    always_comb begin
        new_st = merged;
        if (new_st[ST_WAKE]) new_st[ST_ACTIVE] = 1'b1;
        if (new_st[ST_RUN]) begin
            new_st[ST_ACTIVE] = 1'b1;
            new_st[ST_DEAD]   = 1'b0;
        end
        if (new_st[ST_PAUSE]) new_st[ST_ACTIVE] = 1'b0;
        flush_fire = new_st[ST_FLUSH];
        if (old_st[ST_RUN] && !new_st[ST_RUN]) begin
            new_st[ST_ACTIVE] = 1'b0;
            new_st[ST_DEAD]   = 1'b0;
            new_st[ST_FLUSH]  = 1'b0;
        end
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dmacr_pkg::*;
#(
    parameter int NUM_CH    = 32,
    parameter int WIN_SHIFT = 7,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int ADDR_W   = CH_W + WIN_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:2]   bus_addr,
    input  logic [31:0]         bus_wdata,
    input  logic [3:0]          bus_be,
    output logic [31:0]         bus_rdata,
    output logic [NUM_CH-1:0]   run_req,
    output logic [NUM_CH-1:0]   flush_req,
    output logic [NUM_CH-1:0]   ptr_load,
    output logic [31:0]         ptr_addr
);
    logic [15:0] stat_q [NUM_CH];
    logic [31:0] ptr_q  [NUM_CH];
    logic [31:0] isel_q [NUM_CH];
    logic [31:0] bsel_q [NUM_CH];
    logic [31:0] wsel_q [NUM_CH];

    logic [CH_W-1:0] ch;
    reg_kind_e       kind;
    logic [15:0]     merged_st;
    logic            flush_fire;
    logic            wr_ok, busy;
    logic [31:0]     rd_val;

    dmacr_decode #(.NUM_CH(NUM_CH), .WIN_SHIFT(WIN_SHIFT)) u_decode (
        .word_addr (bus_addr),
        .chan      (ch),
        .kind      (kind)
    );

    dmacr_ctrl_merge u_merge (
        .old_st     (stat_q[ch]),
        .ctrl_word  (bus_wdata),
        .new_st     (merged_st),
        .flush_fire (flush_fire)
    );

    assign wr_ok = bus_wr && (bus_be == 4'hF);
    assign busy  = stat_q[ch][ST_RUN] | stat_q[ch][ST_ACTIVE];

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_run
            assign run_req[g] = stat_q[g][ST_ACTIVE];
        end
    endgenerate

    always_comb begin
        unique case (kind)
            K_STAT:  rd_val = {16'h0, stat_q[ch]};
            K_PTRLO: rd_val = ptr_q[ch];
            K_ISEL:  rd_val = isel_q[ch];
            K_BSEL:  rd_val = bsel_q[ch];
            K_WSEL:  rd_val = wsel_q[ch];
            default: rd_val = 32'h0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                stat_q[i] <= '0;
                ptr_q[i]  <= '0;
                isel_q[i] <= '0;
                bsel_q[i] <= '0;
                wsel_q[i] <= '0;
            end
            flush_req <= '0;
            ptr_load  <= '0;
            ptr_addr  <= '0;
            bus_rdata <= '0;
        end else begin
            flush_req <= '0;
            ptr_load  <= '0;
            if (wr_ok) begin
                unique case (kind)
                    K_CTRL: begin
                        stat_q[ch]    <= merged_st;
                        flush_req[ch] <= flush_fire;
                    end
                    K_STAT: stat_q[ch] <= bus_wdata[15:0];
                    K_PTRLO: begin
                        if (!busy) begin
                            ptr_q[ch]    <= {bus_wdata[31:4], 4'h0};
                            ptr_load[ch] <= 1'b1;
                            ptr_addr     <= {bus_wdata[31:4], 4'h0};
                        end
                    end
                    K_ISEL:  isel_q[ch] <= bus_wdata;
                    K_BSEL:  bsel_q[ch] <= bus_wdata;
                    K_WSEL:  wsel_q[ch] <= bus_wdata;
                    default: ;
                endcase
            end
            if (bus_rd) bus_rdata <= rd_val;
        end
    end

    // Tracks the channel touched by the last control write, for the checks below.
    logic            lc_valid_q;
    logic [CH_W-1:0] lc_ch_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lc_valid_q <= 1'b0;
            lc_ch_q    <= '0;
        end else begin
            lc_valid_q <= wr_ok && (kind == K_CTRL);
            lc_ch_q    <= ch;
        end
    end

    assert_pause_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lc_valid_q |-> !(stat_q[lc_ch_q][ST_PAUSE] && stat_q[lc_ch_q][ST_ACTIVE]));

    assert_run_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lc_valid_q && stat_q[lc_ch_q][ST_RUN] && !stat_q[lc_ch_q][ST_PAUSE])
        |-> (stat_q[lc_ch_q][ST_ACTIVE] && !stat_q[lc_ch_q][ST_DEAD]));

    assert_ptr_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|ptr_load) |-> $past(wr_ok && (kind == K_PTRLO) && !busy));

    assert_flush_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|flush_req) |-> $past(wr_ok && (kind == K_CTRL)));

    assert_strobe_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flush_req) && $onehot0(ptr_load));
endmodule

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;
    localparam int NCH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:2] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] run_req, flush_req, ptr_load;
    logic [31:0] ptr_addr;

    int n_chk = 0, n_bad = 0;
    logic [15:0] m_st  [NCH];
    logic [31:0] m_ptr [NCH];
    logic [31:0] m_sel [3][NCH];

    always #5 clk = ~clk;

    dma_chan_regs i_dma_chan_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .run_req(run_req), .flush_req(flush_req),
        .ptr_load(ptr_load), .ptr_addr(ptr_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected merge: returns {flush, new_status}
    function automatic logic [16:0] f_ctrl(input logic [15:0] old, input logic [31:0] w);
        logic [15:0] s, m, v;
        logic fl;
        m = w[31:16];
        v = w[15:0] & 16'hF0FF;
        s = (v & m) | (old & ~m);
        if (s[12]) s[10] = 1'b1;
        if (s[15]) begin s[10] = 1'b1; s[11] = 1'b0; end
        if (s[14]) s[10] = 1'b0;
        fl = s[13];
        if (old[15] && !s[15]) begin s[10] = 1'b0; s[11] = 1'b0; s[13] = 1'b0; end
        return {fl, s};
    endfunction

    function automatic logic [31:0] f_read(input int c, input int r);
        case (r)
            1: return {16'h0, m_st[c]};
            3: return m_ptr[c];
            4, 5, 6: return m_sel[r-4][c];
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [NCH-1:0] f_active();
        logic [NCH-1:0] a;
        for (int i = 0; i < NCH; i++) a[i] = m_st[i][10];
        return a;
    endfunction

    task automatic do_write(input int c, input int r, input logic [31:0] d,
                            input logic [3:0] be, input string tag);
        logic [NCH-1:0] ef, el;
        logic [16:0] res;
        logic [31:0] eaddr;
        ef = '0; el = '0; eaddr = ptr_addr;
        @(negedge clk);
        bus_addr = {c[4:0], r[4:0]}; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        if (be == 4'hF) begin
            case (r)
                0: begin res = f_ctrl(m_st[c], d); m_st[c] = res[15:0]; ef[c] = res[16]; end
                1: m_st[c] = d[15:0];
                3: if (!(m_st[c][15] || m_st[c][10])) begin
                       m_ptr[c] = {d[31:4], 4'h0}; el[c] = 1'b1; eaddr = m_ptr[c];
                   end
                4, 5, 6: m_sel[r-4][c] = d;
                default: ;
            endcase
        end
        @(posedge clk); #1;
        bus_wr = 1'b0;
        chk({tag, " R7 flush strobe"}, flush_req, ef);
        chk({tag, " R8 load strobe"}, ptr_load, el);
        chk({tag, " R8 ptr_addr"}, ptr_addr, eaddr);
        chk({tag, " R11 run_req"}, run_req, f_active());
    endtask

    task automatic do_read(input int c, input int r, input string tag);
        @(negedge clk);
        bus_addr = {c[4:0], r[4:0]}; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        chk({tag, " R10 rdata"}, bus_rdata, f_read(c, r));
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NCH; i++) begin
            m_st[i] = '0; m_ptr[i] = '0;
            for (int k = 0; k < 3; k++) m_sel[k][i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk("R1 run_req", run_req, '0);
        chk("R1 flush_req", flush_req, '0);
        chk("R1 rdata", bus_rdata, '0);
        do_read(0, 1, "R1 st0");
        do_read(31, 3, "R1 ptr31");
        do_read(17, 5, "R1 bsel17");

        // R2: addressing and strobe filtering
        do_write(31, 4, 32'hCAFE_0123, 4'hF, "R2 isel31");
        do_read(31, 4, "R2 isel31");
        do_read(30, 4, "R2 isel30");
        do_write(31, 4, 32'h1111_1111, 4'h3, "R2 partial");
        do_read(31, 4, "R2 partial ignored");
        do_write(5, 0, 32'hFFFF_9000, 4'h7, "R2 partial ctrl");
        chk("R2 partial ctrl no run", run_req[5], 1'b0);

        // R3: masked merge, non-accepted bits forced to 0
        do_write(2, 1, 32'h0000_0B5A, 4'hF, "R9 st write");
        do_read(2, 1, "R9 st");
        do_write(2, 0, 32'h00FF_00C3, 4'hF, "R3 devstat");
        do_read(2, 1, "R3 devstat");
        chk("R3 literal", bus_rdata, 32'h0000_0BC3);
        do_write(2, 0, 32'h0800_0800, 4'hF, "R3 dead not accepted");
        do_read(2, 1, "R3 dead cleared");
        do_read(2, 0, "R10 ctrl reads 0");

        // R4/R5: WAKE, RUN, PAUSE priority
        do_write(3, 0, 32'h1000_1000, 4'hF, "R4 wake");
        chk("R4 wake active", run_req[3], 1'b1);
        do_write(4, 0, 32'hC000_C000, 4'hF, "R5 run+pause");
        chk("R5 pause wins", run_req[4], 1'b0);
        do_write(4, 0, 32'h4000_0000, 4'hF, "R5 unpause");
        chk("R4 run active", run_req[4], 1'b1);

        // R8: pointer locked while running
        do_write(4, 3, 32'h1234_5678, 4'hF, "R8 locked");
        do_read(4, 3, "R8 locked");
        // R6/R7: run fall with flush
        do_write(4, 0, 32'h2000_2000, 4'hF, "R7 flush while run");
        do_write(4, 0, 32'h8000_0000, 4'hF, "R6 run fall");
        do_read(4, 1, "R6 status");
        chk("R6 literal", bus_rdata, 32'h0);
        do_write(4, 3, 32'h1234_567F, 4'hF, "R8 accepted");
        chk("R8 aligned", ptr_addr, 32'h1234_5670);
        do_read(4, 3, "R8 readback");
        do_read(4, 7, "R10 xfer mode");
        do_read(4, 13, "R10 reserved");

        // Random mix
        for (int it = 0; it < 600; it++) begin
            int c, r, p;
            logic [31:0] d;
            logic [3:0] be;
            c = (($urandom_range(0, 9) == 0) ? 31 : $urandom_range(0, 3));
            p = $urandom_range(0, 99);
            r = (p < 40) ? 0 : (p < 55) ? 3 : (p < 65) ? 1 : $urandom_range(2, 15);
            d = $urandom;
            if (r == 0) d[15:12] = $urandom_range(0, 15);
            be = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 15)) : 4'hF;
            do_write(c, r, d, be, "RND write");
            do_read(c, $urandom_range(0, 15), "RND read");
            if (it % 50 == 0) do_read(c, 1, "RND R3 status");
        end
        finish_run();
    end
endmodule